// File: doc/BRIEF.md
# Packet Framer with CRC16

This block assembles outgoing radio packets and takes incoming ones apart, one byte per handshake toward the symbol layer. A transmitted frame is made of optional preamble bytes, an optional two-byte start-of-packet code, an optional length byte, the payload read from a small transmit buffer, and an optional CRC16. Each field is switched on its own, so the same block can talk to a peer that uses full framing and to a legacy peer that uses none of it.

On receive, the block hunts for the start-of-packet code when that field is on. It then takes the length, or a fixed length from configuration when the length field is off. Payload bytes go into a receive buffer that is read one byte at a time. The block runs the CRC over the frame and raises a completion flag with a CRC-valid bit, an overflow bit and the length seen. Software clears the flags by pulsing a status-read strobe. While a finished frame is still unread, an overwrite option decides whether the next frame may replace it.

Top module: `pkt_framer`

## Requirements
- R1: After `tx_start`, the transmit stream carries, in this order, `cfg_pre_cnt` copies of `cfg_pre_byte`, then the SOP code high byte and low byte (if `cfg_sop_en`), then the length byte `tx_len` (if `cfg_len_en`), then `tx_len` payload bytes from transmit-buffer addresses 0, 1, 2 and so on, then the CRC high byte and low byte (if `cfg_tx_crc`). A field that is disabled, or that has a count of zero, is left out. A start with every field empty sends nothing.
- R2: The CRC uses the polynomial 0x1021. Bits are taken MSB first, starting from `cfg_seed`, with no final inversion. It covers the length byte (when present) and the payload, and not the preamble or the SOP code.
- R3: While `tx_vld` is high and `tx_rdy` is low, `tx_vld` and `tx_byte` hold their values. A byte is transferred on an edge where both signals are high. `tx_busy` is high whenever `tx_vld` is high, and it goes low on the edge that transfers the last byte.
- R4: With `cfg_sop_en` high, a receive frame begins only after a byte equal to `cfg_sop_code[15:8]` is followed directly by a byte equal to `cfg_sop_code[7:0]`. Other bytes are ignored, and a repeated high byte keeps the match pending. With `cfg_sop_en` low, the first byte received is the first field of a frame.
- R5: With `cfg_len_en` high, the first field byte is the payload length. With it low, the frame carries `cfg_fix_len` payload bytes, and `cfg_fix_len` must be at least 1. Payload byte i is stored at receive-buffer address i. A read with `rxb_rd` high and `rxb_addr` presents the stored byte on `rxb_rdata` one edge later.
- R6: When the length exceeds DEPTH, payload bytes past address DEPTH-1 are dropped, `st_ovf` is set with completion, and `st_len` still reports the received length.
- R7: `st_crc_ok` is 1 when `cfg_rx_chk` is low, whatever the CRC bytes hold. When `cfg_rx_chk` is high, `st_crc_ok` is 1 only if three conditions all hold: `cfg_rx_crc` is high, the two received CRC bytes equal the R2 CRC of the frame, and it is not the case that `cfg_rej_zero` is high with `cfg_seed` equal to zero.
- R8: `st_done` rises on the edge that accepts the last byte of a frame. That byte is the second CRC byte when `cfg_rx_crc` is high. Otherwise it is the last payload byte, or the length byte if the length is zero. `st_crc_ok`, `st_ovf` and `st_len` update on that same edge.
- R9: A `stat_rd` pulse clears `st_done`, `st_crc_ok` and `st_ovf` on the next edge. The only exception is a frame completing on that same edge, whose status then stands.
- R10: When a frame begins while `st_done` is high and `cfg_ovw` is low, the frame is parsed but leaves the receive buffer and all status untouched. With `cfg_ovw` high, it replaces both.
- R11: Reset is synchronous and active high. It drives `tx_vld`, `tx_busy`, `st_done`, `st_crc_ok` and `st_ovf` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_sop_en | input | 1 | SOP code field present |
| cfg_sop_code | input | 16 | SOP code value |
| cfg_len_en | input | 1 | Length field present |
| cfg_fix_len | input | 8 | Receive payload count when length field absent |
| cfg_seed | input | 16 | CRC start value |
| cfg_pre_cnt | input | PRE_W | Number of preamble bytes sent |
| cfg_pre_byte | input | 8 | Preamble byte value |
| cfg_tx_crc | input | 1 | Append CRC on transmit |
| cfg_rx_crc | input | 1 | Receive frames carry a CRC field |
| cfg_rx_chk | input | 1 | Enforce CRC on receive |
| cfg_rej_zero | input | 1 | Reject when the seed is zero |
| cfg_ovw | input | 1 | Allow overwrite of unread frame |
| txb_we | input | 1 | Transmit buffer write enable |
| txb_addr | input | AW | Transmit buffer write address |
| txb_wdata | input | 8 | Transmit buffer write data |
| tx_start | input | 1 | Start sending a frame |
| tx_len | input | 8 | Transmit payload length, at most DEPTH |
| tx_busy | output | 1 | Frame in progress |
| tx_vld | output | 1 | Transmit byte valid |
| tx_rdy | input | 1 | Symbol layer accepts byte |
| tx_byte | output | 8 | Transmit byte |
| rx_vld | input | 1 | Receive byte valid |
| rx_byte | input | 8 | Receive byte |
| rxb_rd | input | 1 | Receive buffer read strobe |
| rxb_addr | input | AW | Receive buffer read address |
| rxb_rdata | output | 8 | Receive buffer read data |
| stat_rd | input | 1 | Status read, clears flags |
| st_done | output | 1 | Frame complete |
| st_crc_ok | output | 1 | Frame accepted by CRC policy |
| st_ovf | output | 1 | Payload exceeded buffer |
| st_len | output | 8 | Length of the last frame |

## Verification
Receive status is due on the first edge after the final byte of a frame is presented. The bench therefore samples it at the falling edge that follows that byte, before any other stimulus. Buffer read data and flag clearing each appear one edge after their strobe, and they are sampled at the next falling edge. Transmit bytes are checked by handshake order rather than by cycle: on each falling edge the bench records a byte only where valid and ready are both high, and it compares the collected frame with one built by its own model once busy drops.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [2:0] {
    T_IDLE, T_PRE, T_SOP0, T_SOP1, T_LEN, T_DATA, T_CRC0, T_CRC1
  } tx_st_t;

  typedef enum logic [2:0] {
    R_HUNT, R_SOP1, R_LEN, R_DATA, R_CRC0, R_CRC1
  } rx_st_t;

  // one byte through the CRC register, MSB first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/pf_ram.sv
module pf_ram #(
  parameter int DEPTH  = 8,
  parameter int WIDTH  = 8,
  parameter bit REG_RD = 1'b1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  generate
    if (REG_RD) begin : g_sync
      always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
      end
    end else begin : g_async
      logic unused_re;
      assign unused_re = re;
      assign rdata = mem[raddr];
    end
  endgenerate
endmodule

// File: rtl/pf_tx.sv
module pf_tx
  import pf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PRE_W = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] cfg_pre_cnt,
  input  logic [7:0]       cfg_pre_byte,
  input  logic             cfg_sop_en,
  input  logic [15:0]      cfg_sop_code,
  input  logic             cfg_len_en,
  input  logic             cfg_crc_en,
  input  logic [15:0]      cfg_seed,
  input  logic             start,
  input  logic [7:0]       len,
  output logic             busy,
  output logic [AW-1:0]    buf_addr,
  input  logic [7:0]       buf_data,
  output logic             o_vld,
  input  logic             o_rdy,
  output logic [7:0]       o_byte
);
  tx_st_t           st;
  logic [PRE_W-1:0] pcnt;
  logic [7:0]       idx, plen, cur;
  logic [15:0]      crc;
  logic [7:0]       en_now, en_go;
  logic             load;

  // lowest enabled stage after s, or idle
  function automatic tx_st_t nxt(input tx_st_t s, input logic [7:0] e);
    tx_st_t r;
    r = T_IDLE;
    for (int k = 7; k >= 1; k--)
      if (k > int'(s) && e[k]) r = tx_st_t'(k);
    return r;
  endfunction

  assign en_now = {cfg_crc_en, cfg_crc_en, plen != 8'd0, cfg_len_en,
                   cfg_sop_en, cfg_sop_en, cfg_pre_cnt != '0, 1'b0};
  assign en_go  = {cfg_crc_en, cfg_crc_en, len != 8'd0, cfg_len_en,
                   cfg_sop_en, cfg_sop_en, cfg_pre_cnt != '0, 1'b0};
  assign load     = !o_vld || o_rdy;
  assign busy     = (st != T_IDLE) || o_vld;
  assign buf_addr = idx[AW-1:0];

  always_comb begin
    case (st)
      T_PRE:   cur = cfg_pre_byte;
      T_SOP0:  cur = cfg_sop_code[15:8];
      T_SOP1:  cur = cfg_sop_code[7:0];
      T_LEN:   cur = plen;
      T_DATA:  cur = buf_data;
      T_CRC0:  cur = crc[15:8];
      T_CRC1:  cur = crc[7:0];
      default: cur = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= T_IDLE; o_vld <= 1'b0; o_byte <= '0;
      pcnt <= '0; idx <= '0; plen <= '0; crc <= '0;
    end else if (st == T_IDLE) begin
      if (load) o_vld <= 1'b0;
      if (start && !o_vld) begin
        st   <= nxt(T_IDLE, en_go);
        plen <= len;
        crc  <= cfg_seed;
        pcnt <= '0;
        idx  <= '0;
      end
    end else if (load) begin
      o_vld  <= 1'b1;
      o_byte <= cur;
      case (st)
        T_PRE: begin
          pcnt <= pcnt + 1'b1;
          if (pcnt == cfg_pre_cnt - 1'b1) st <= nxt(st, en_now);
        end
        T_LEN: begin
          crc <= crc16_step(crc, plen);
          st  <= nxt(st, en_now);
        end
        T_DATA: begin
          crc <= crc16_step(crc, buf_data);
          idx <= idx + 1'b1;
          if (idx == plen - 1'b1) st <= nxt(st, en_now);
        end
        default: st <= nxt(st, en_now);
      endcase
    end
  end
endmodule

// File: rtl/pf_rx.sv
module pf_rx
  import pf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam logic [7:0] CAP = 8'(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_sop_en,
  input  logic [15:0]   cfg_sop_code,
  input  logic          cfg_len_en,
  input  logic [7:0]    cfg_fix_len,
  input  logic          cfg_crc_en,
  input  logic          cfg_chk,
  input  logic          cfg_rej_zero,
  input  logic          cfg_ovw,
  input  logic [15:0]   cfg_seed,
  input  logic          in_vld,
  input  logic [7:0]    in_byte,
  input  logic          stat_rd,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          done,
  output logic          crc_ok,
  output logic          ovf,
  output logic [7:0]    len_out
);
  rx_st_t      st, n_st, fld, first;
  logic [7:0]  cnt, n_cnt, plen, n_len;
  logic [15:0] crc, n_crc;
  logic        drop, n_drop, ovf_acc, n_ovf, fin, proc, good;

  assign first   = cfg_len_en ? R_LEN : R_DATA;
  assign wr_data = in_byte;

  always_comb begin
    n_st = st; n_cnt = cnt; n_len = plen; n_crc = crc;
    n_drop = drop; n_ovf = ovf_acc;
    fin = 1'b0; wr_en = 1'b0; proc = 1'b0; fld = st;
    wr_addr = cnt[AW-1:0];
    if (in_vld) begin
      case (st)
        R_HUNT: begin
          if (cfg_sop_en) begin
            if (in_byte == cfg_sop_code[15:8]) n_st = R_SOP1;
          end else begin
            proc = 1'b1; fld = first;
            n_cnt = '0; n_len = cfg_fix_len; n_crc = cfg_seed;
            n_drop = done && !cfg_ovw; n_ovf = 1'b0;
          end
        end
        R_SOP1: begin
          if (in_byte == cfg_sop_code[7:0]) begin
            n_st = first;
            n_cnt = '0; n_len = cfg_fix_len; n_crc = cfg_seed;
            n_drop = done && !cfg_ovw; n_ovf = 1'b0;
          end else if (in_byte != cfg_sop_code[15:8]) begin
            n_st = R_HUNT;
          end
        end
        default: proc = 1'b1;
      endcase
    end
    if (proc) begin
      case (fld)
        R_LEN: begin
          n_len = in_byte;
          n_crc = crc16_step(n_crc, in_byte);
          if (in_byte != 8'd0)  n_st = R_DATA;
          else if (cfg_crc_en)  n_st = R_CRC0;
          else begin n_st = R_HUNT; fin = 1'b1; end
        end
        R_DATA: begin
          n_crc   = crc16_step(n_crc, in_byte);
          wr_addr = n_cnt[AW-1:0];
          if (n_cnt < CAP) wr_en = !n_drop;
          else             n_ovf = 1'b1;
          if (n_cnt == n_len - 1'b1) begin
            if (cfg_crc_en) n_st = R_CRC0;
            else begin n_st = R_HUNT; fin = 1'b1; end
          end else begin
            n_st = R_DATA;
          end
          n_cnt = n_cnt + 1'b1;
        end
        R_CRC0: begin
          n_crc = crc16_step(n_crc, in_byte);
          n_st  = R_CRC1;
        end
        R_CRC1: begin
          n_crc = crc16_step(n_crc, in_byte);
          n_st  = R_HUNT;
          fin   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // residue of zero after the CRC bytes means a match
  assign good = !cfg_chk ||
                (cfg_crc_en && n_crc == 16'h0000 && !(cfg_rej_zero && cfg_seed == 16'h0000));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= R_HUNT; cnt <= '0; plen <= '0; crc <= '0; drop <= 1'b0; ovf_acc <= 1'b0;
      done <= 1'b0; crc_ok <= 1'b0; ovf <= 1'b0; len_out <= '0;
    end else begin
      st <= n_st; cnt <= n_cnt; plen <= n_len; crc <= n_crc;
      drop <= n_drop; ovf_acc <= n_ovf;
      if (stat_rd) begin
        done <= 1'b0; crc_ok <= 1'b0; ovf <= 1'b0;
      end
      if (fin && !n_drop) begin
        done <= 1'b1; crc_ok <= good; ovf <= n_ovf; len_out <= n_len;
      end
    end
  end
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int DEPTH = 8,
  parameter int PRE_W = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_sop_en,
  input  logic [15:0]      cfg_sop_code,
  input  logic             cfg_len_en,
  input  logic [7:0]       cfg_fix_len,
  input  logic [15:0]      cfg_seed,
  input  logic [PRE_W-1:0] cfg_pre_cnt,
  input  logic [7:0]       cfg_pre_byte,
  input  logic             cfg_tx_crc,
  input  logic             cfg_rx_crc,
  input  logic             cfg_rx_chk,
  input  logic             cfg_rej_zero,
  input  logic             cfg_ovw,
  input  logic             txb_we,
  input  logic [AW-1:0]    txb_addr,
  input  logic [7:0]       txb_wdata,
  input  logic             tx_start,
  input  logic [7:0]       tx_len,
  output logic             tx_busy,
  output logic             tx_vld,
  input  logic             tx_rdy,
  output logic [7:0]       tx_byte,
  input  logic             rx_vld,
  input  logic [7:0]       rx_byte,
  input  logic             rxb_rd,
  input  logic [AW-1:0]    rxb_addr,
  output logic [7:0]       rxb_rdata,
  input  logic             stat_rd,
  output logic             st_done,
  output logic             st_crc_ok,
  output logic             st_ovf,
  output logic [7:0]       st_len
);
  logic [AW-1:0] tx_raddr, rx_waddr;
  logic [7:0]    tx_rdata, rx_wdata;
  logic          rx_we;

  pf_ram #(.DEPTH(DEPTH), .WIDTH(8), .REG_RD(1'b0)) i_txbuf (
    .clk(clk), .we(txb_we), .waddr(txb_addr), .wdata(txb_wdata),
    .re(1'b1), .raddr(tx_raddr), .rdata(tx_rdata));

  pf_tx #(.DEPTH(DEPTH), .PRE_W(PRE_W)) i_tx (
    .clk(clk), .rst(rst),
    .cfg_pre_cnt(cfg_pre_cnt), .cfg_pre_byte(cfg_pre_byte),
    .cfg_sop_en(cfg_sop_en), .cfg_sop_code(cfg_sop_code),
    .cfg_len_en(cfg_len_en), .cfg_crc_en(cfg_tx_crc), .cfg_seed(cfg_seed),
    .start(tx_start), .len(tx_len), .busy(tx_busy),
    .buf_addr(tx_raddr), .buf_data(tx_rdata),
    .o_vld(tx_vld), .o_rdy(tx_rdy), .o_byte(tx_byte));

  pf_rx #(.DEPTH(DEPTH)) i_rx (
    .clk(clk), .rst(rst),
    .cfg_sop_en(cfg_sop_en), .cfg_sop_code(cfg_sop_code),
    .cfg_len_en(cfg_len_en), .cfg_fix_len(cfg_fix_len),
    .cfg_crc_en(cfg_rx_crc), .cfg_chk(cfg_rx_chk),
    .cfg_rej_zero(cfg_rej_zero), .cfg_ovw(cfg_ovw), .cfg_seed(cfg_seed),
    .in_vld(rx_vld), .in_byte(rx_byte), .stat_rd(stat_rd),
    .wr_en(rx_we), .wr_addr(rx_waddr), .wr_data(rx_wdata),
    .done(st_done), .crc_ok(st_crc_ok), .ovf(st_ovf), .len_out(st_len));

  pf_ram #(.DEPTH(DEPTH), .WIDTH(8), .REG_RD(1'b1)) i_rxbuf (
    .clk(clk), .we(rx_we), .waddr(rx_waddr), .wdata(rx_wdata),
    .re(rxb_rd), .raddr(rxb_addr), .rdata(rxb_rdata));
endmodule

// File: rtl/pf_chk.sv
module pf_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_vld,
  input logic       tx_rdy,
  input logic [7:0] tx_byte,
  input logic       tx_busy,
  input logic       rx_vld,
  input logic       stat_rd,
  input logic       st_done,
  input logic       st_crc_ok,
  input logic       st_ovf
);
  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_vld && !tx_rdy |=> tx_vld && $stable(tx_byte));

  // R3
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    tx_vld |-> tx_busy);

  // R8
  done_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_done) |-> $past(rx_vld));

  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd && !rx_vld |=> !st_done && !st_crc_ok && !st_ovf);

  // R7
  crc_ok_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    st_crc_ok |-> st_done);

  // R6
  ovf_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    st_ovf |-> st_done);
endmodule

bind pkt_framer pf_chk i_pf_chk (.*);

// File: tb/test_pkt_framer.sv
`timescale 1ns/1ps
module test_pkt_framer;
  localparam int DEPTH = 8;
  localparam int AW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_sop_en = 0, cfg_len_en = 0, cfg_tx_crc = 0, cfg_rx_crc = 0;
  logic cfg_rx_chk = 0, cfg_rej_zero = 0, cfg_ovw = 0;
  logic [15:0] cfg_sop_code = 16'hB25E, cfg_seed = 16'hFFFF;
  logic [7:0] cfg_fix_len = 8'd1, cfg_pre_byte = 8'h55;
  logic [3:0] cfg_pre_cnt = 4'd0;
  logic txb_we = 0; logic [AW-1:0] txb_addr = '0; logic [7:0] txb_wdata = '0;
  logic tx_start = 0; logic [7:0] tx_len = '0; logic tx_rdy = 1;
  logic tx_busy, tx_vld; logic [7:0] tx_byte;
  logic rx_vld = 0; logic [7:0] rx_byte = '0;
  logic rxb_rd = 0; logic [AW-1:0] rxb_addr = '0; logic [7:0] rxb_rdata;
  logic stat_rd = 0, st_done, st_crc_ok, st_ovf; logic [7:0] st_len;

  int checks = 0, fails = 0;
  logic [7:0] pay [16];
  logic [7:0] fq[$];
  logic [7:0] got[$];

  always #4 clk = ~clk;

  pkt_framer #(.DEPTH(DEPTH), .PRE_W(4)) i_pkt_framer (.*);

  task automatic chk(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s %s", req, what); end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic build(input int pre, input bit sop, input bit lenf, input int n,
                       input bit crcf, input bit corrupt);
    logic [15:0] c;
    fq.delete();
    for (int i = 0; i < pre; i++) fq.push_back(cfg_pre_byte);
    if (sop) begin fq.push_back(cfg_sop_code[15:8]); fq.push_back(cfg_sop_code[7:0]); end
    c = cfg_seed;
    if (lenf) begin fq.push_back(8'(n)); c = ref_crc(c, 8'(n)); end
    for (int i = 0; i < n; i++) begin fq.push_back(pay[i]); c = ref_crc(c, pay[i]); end
    if (crcf) begin fq.push_back(c[15:8] ^ {7'd0, corrupt}); fq.push_back(c[7:0]); end
  endtask

  task automatic tx_case(input int n);
    int guard;
    bit same;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); txb_we = 1; txb_addr = AW'(i); txb_wdata = pay[i];
    end
    @(negedge clk); txb_we = 0;
    build(int'(cfg_pre_cnt), cfg_sop_en, cfg_len_en, n, cfg_tx_crc, 1'b0);
    tx_len = 8'(n); tx_start = 1;
    @(negedge clk); tx_start = 0;
    got.delete(); guard = 0;
    while (tx_busy && guard < 1000) begin
      tx_rdy = ($urandom % 4) != 0;
      if (tx_vld && tx_rdy) got.push_back(tx_byte);
      @(negedge clk); guard++;
    end
    tx_rdy = 1;
    same = (got.size() == fq.size());
    if (same) foreach (fq[i]) if (got[i] !== fq[i]) same = 0;
    // R1 field order, R2 CRC bytes
    chk(same, "R1/R2", $sformatf("tx frame bytes=%0d exp=%0d first=%h exp_first=%h",
        got.size(), fq.size(), got.size() ? got[0] : 8'h0, fq.size() ? fq[0] : 8'h0));
    chk(!tx_busy && !tx_vld, "R3", $sformatf("idle after frame busy=%b vld=%b exp 0 0", tx_busy, tx_vld));
  endtask

  task automatic rx_send();
    foreach (fq[i]) begin
      rx_vld = 1; rx_byte = fq[i];
      @(negedge clk); rx_vld = 0;
      repeat ($urandom % 3) @(negedge clk);
    end
  endtask

  task automatic rx_expect(input bit eok, input int n, input int nbuf, input string req);
    chk(st_done === 1'b1, "R8", $sformatf("%s done=%b exp 1", req, st_done));
    chk(st_crc_ok === eok, "R7", $sformatf("%s crc_ok=%b exp %b", req, st_crc_ok, eok));
    chk(st_ovf === (n > DEPTH), "R6", $sformatf("%s ovf=%b exp %b", req, st_ovf, n > DEPTH));
    chk(st_len === 8'(n), "R5", $sformatf("%s len=%0d exp %0d", req, st_len, n));
    for (int i = 0; i < nbuf; i++) begin
      @(negedge clk); rxb_rd = 1; rxb_addr = AW'(i);
      @(negedge clk); rxb_rd = 0;
      chk(rxb_rdata === pay[i], "R5", $sformatf("%s buf[%0d]=%h exp %h", req, i, rxb_rdata, pay[i]));
    end
  endtask

  task automatic clear_status();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    chk(!st_done && !st_crc_ok && !st_ovf, "R9",
        $sformatf("after read done=%b ok=%b ovf=%b exp 0 0 0", st_done, st_crc_ok, st_ovf));
  endtask

  task automatic rand_pay();
    for (int i = 0; i < 16; i++) pay[i] = 8'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog timeout actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    bit eok, corrupt;
    logic [7:0] saved [16];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(!tx_vld && !tx_busy && !st_done && !st_crc_ok && !st_ovf, "R11",
        $sformatf("reset vld=%b busy=%b done=%b ok=%b ovf=%b exp all 0",
                  tx_vld, tx_busy, st_done, st_crc_ok, st_ovf));

    // R1 empty frame sends nothing
    cfg_pre_cnt = 0; cfg_sop_en = 0; cfg_len_en = 0; cfg_tx_crc = 0;
    rand_pay(); tx_case(0);

    // random transmit frames
    for (int t = 0; t < 30; t++) begin
      rand_pay();
      cfg_pre_cnt = 4'($urandom % 5); cfg_sop_en = 1'($urandom); cfg_len_en = 1'($urandom);
      cfg_tx_crc = 1'($urandom); cfg_seed = 16'($urandom); cfg_sop_code = 16'($urandom);
      tx_case($urandom % (DEPTH + 1));
    end

    // random receive frames
    cfg_pre_byte = 8'h55;
    for (int t = 0; t < 30; t++) begin
      rand_pay();
      cfg_sop_en = 1'($urandom); cfg_len_en = 1'($urandom);
      cfg_rx_crc = 1'($urandom); cfg_rx_chk = 1'($urandom); cfg_rej_zero = 1'($urandom);
      cfg_seed = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom);
      cfg_sop_code = {8'hC3 ^ 8'($urandom % 16), 8'($urandom)};
      n = cfg_len_en ? int'($urandom % 12) : 1 + int'($urandom % 8);
      cfg_fix_len = 8'(n);
      corrupt = cfg_rx_crc && ($urandom % 3 == 0);
      eok = !cfg_rx_chk || (cfg_rx_crc && !corrupt && !(cfg_rej_zero && cfg_seed == 16'h0));
      build(cfg_sop_en ? 2 : 0, cfg_sop_en, cfg_len_en, n, cfg_rx_crc, corrupt);
      rx_send();
      rx_expect(eok, n, (n > DEPTH) ? DEPTH : n, "random");
      clear_status();
    end

    // R4 false starts before the SOP code
    rand_pay();
    cfg_sop_en = 1; cfg_len_en = 1; cfg_rx_crc = 1; cfg_rx_chk = 1; cfg_rej_zero = 0;
    cfg_sop_code = 16'hB25E; cfg_seed = 16'h1D0F;
    build(0, 1, 1, 3, 1, 0);
    fq.push_front(8'hB2); fq.push_front(8'h11); fq.push_front(8'hB2); fq.push_front(8'h5E);
    rx_send();
    rx_expect(1'b1, 3, 3, "R4 sop hunt");
    clear_status();

    // R7 zero seed rejected, then accepted when rejection off
    cfg_seed = 16'h0000; cfg_rej_zero = 1;
    build(0, 1, 1, 4, 1, 0); rx_send();
    rx_expect(1'b0, 4, 4, "R7 zero seed reject");
    clear_status();
    cfg_rej_zero = 0;
    build(0, 1, 1, 4, 1, 0); rx_send();
    rx_expect(1'b1, 4, 4, "R7 zero seed allowed");
    clear_status();

    // R7 checking off accepts a bad CRC
    cfg_seed = 16'hACE1; cfg_rx_chk = 0;
    build(0, 1, 1, 2, 1, 1); rx_send();
    rx_expect(1'b1, 2, 2, "R7 check off");
    clear_status();
    cfg_rx_chk = 1;

    // R6 overflow
    rand_pay();
    build(0, 1, 1, 11, 1, 0); rx_send();
    rx_expect(1'b1, 11, DEPTH, "R6 overflow");
    clear_status();

    // R10 unread frame kept when overwrite off
    rand_pay();
    cfg_ovw = 0;
    build(0, 1, 1, 5, 1, 0); rx_send();
    for (int i = 0; i < 16; i++) saved[i] = pay[i];
    rand_pay();
    build(0, 1, 1, 3, 1, 1); rx_send();
    for (int i = 0; i < 16; i++) pay[i] = saved[i];
    rx_expect(1'b1, 5, 5, "R10 protected");
    // R10 overwrite on replaces
    rand_pay();
    cfg_ovw = 1;
    build(0, 1, 1, 3, 1, 1); rx_send();
    rx_expect(1'b0, 3, 3, "R10 overwrite");
    clear_status();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule